// File: doc/BRIEF.md
# Instruction Address Range Filter

This block holds a small bank of instruction-address range comparators used by a trace unit to decide when tracing is allowed and when it must stop. Each range owns a base register, a limit register and a 4-bit mode field. In every cycle the block compares the current instruction pointer against every range in filter mode and raises a combined filter-enable. It also compares the target of a taken branch against every range in stop mode and raises a one-cycle trace-stop pulse.

Software programs the ranges through a single write port that selects a range and one of its three registers. Mode writes are screened before they land. A mode write with a reserved code is refused with a fault pulse, and so is a nonzero mode write to a range index that this instance does not implement. The number of implemented ranges is a parameter from 1 to 4.

Top module: `ipf_range_filter`

## Requirements
- R1: After reset all mode fields read as unused (0), so filter_en_o is 1, trace_stop_o is 0 and wr_fault_o is 0.
- R2: Mode code 1 makes the inclusive span [base, limit] a filter window. filter_en_o is 1 on the cycle after ip_i lies inside an enabled window. With at least one window enabled, filter_en_o is 0 on the cycle after ip_i lies inside none of them.
- R3: With several filter windows enabled, filter_en_o is the OR of their individual matches.
- R4: When no range holds mode 1, filter_en_o is 1 whatever the value of ip_i, including when ranges are in stop mode.
- R5: A range whose base is greater than its limit never matches, whether it is in filter or in stop mode.
- R6: Mode code 2 makes [base, limit] a stop region. trace_stop_o is 1 for the single cycle after a cycle in which branch_i is 1 and branch_tgt_i lies inside a stop region.
- R7: trace_stop_o stays 0 after any cycle in which branch_i is 0, even when ip_i or branch_tgt_i lies inside a stop region.
- R8: A mode write with code 3 to 15 in wr_data_i[3:0] raises wr_fault_o on the next cycle and leaves that mode field unchanged.
- R9: A mode write to range index n with n >= IMPL_RANGES faults when wr_data_i[3:0] is nonzero. It is accepted without a fault when the value is zero.
- R10: wr_kind_i selects the target register: 0 base, 1 limit, 2 mode. Kind 3 is reserved: it raises wr_fault_o on the next cycle and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ip_i | input | ADDR_W | Current instruction pointer |
| branch_i | input | 1 | Taken-branch strobe |
| branch_tgt_i | input | ADDR_W | Target address of the taken branch |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Register select: 0 base, 1 limit, 2 mode, 3 reserved |
| wr_sel_i | input | 2 | Range index |
| wr_data_i | input | ADDR_W | Write data; a mode write uses bits [3:0] |
| filter_en_o | output | 1 | Combined filter-enable, registered |
| trace_stop_o | output | 1 | Trace-stop pulse, registered |
| wr_fault_o | output | 1 | Rejected-write pulse, registered |

## Verification
Every result is one register stage deep. wr_fault_o reflects a write one clock edge after that write is sampled. filter_en_o and trace_stop_o reflect ip_i, branch_i and branch_tgt_i one edge after they are sampled, and a register write is in force for address inputs sampled on the following edge. The bench changes every input on the falling edge, lets exactly one rising edge pass, and reads the outputs 1 ns later. Each output is therefore compared against a model holding the inputs and register contents of exactly that edge. The bench sweeps all 64 addresses of a 6-bit configuration with three implemented ranges, under several range layouts.

// File: rtl/ipf_pkg.sv
package ipf_pkg;
  localparam int unsigned SLOT_MAX = 4;
  localparam int unsigned SEL_W    = $clog2(SLOT_MAX);
  localparam int unsigned CFG_W    = 4;

  typedef enum logic [1:0] {
    WK_BASE  = 2'd0,
    WK_LIMIT = 2'd1,
    WK_CFG   = 2'd2,
    WK_RSVD  = 2'd3
  } wr_kind_e;

  localparam logic [CFG_W-1:0] RC_OFF  = 4'd0;
  localparam logic [CFG_W-1:0] RC_FILT = 4'd1;
  localparam logic [CFG_W-1:0] RC_STOP = 4'd2;
endpackage

// File: rtl/ipf_wr_decode.sv
module ipf_wr_decode
  import ipf_pkg::*;
#(
  parameter int unsigned IMPL_RANGES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [1:0]             wr_kind_i,
  input  logic [SEL_W-1:0]       wr_sel_i,
  input  logic [CFG_W-1:0]       wr_code_i,
  output logic [IMPL_RANGES-1:0] we_base_o,
  output logic [IMPL_RANGES-1:0] we_limit_o,
  output logic [IMPL_RANGES-1:0] we_cfg_o,
  output logic                   fault_o
);
  logic fault_d;
  logic sel_impl;

  assign sel_impl = (int'(wr_sel_i) < int'(IMPL_RANGES));

  always_comb begin
    fault_d = 1'b0;
    if (wr_en_i) begin
      unique case (wr_kind_i)
        WK_RSVD: fault_d = 1'b1;
        WK_CFG: begin
          if (wr_code_i > RC_STOP) fault_d = 1'b1;
          else if (!sel_impl && wr_code_i != RC_OFF) fault_d = 1'b1;
        end
        default: fault_d = 1'b0;
      endcase
    end
  end

  for (genvar g = 0; g < IMPL_RANGES; g++) begin : g_we
    logic hit;
    assign hit           = wr_en_i && !fault_d && (wr_sel_i == SEL_W'(g));
    assign we_base_o[g]  = hit && (wr_kind_i == WK_BASE);
    assign we_limit_o[g] = hit && (wr_kind_i == WK_LIMIT);
    assign we_cfg_o[g]   = hit && (wr_kind_i == WK_CFG);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_o <= 1'b0;
    else         fault_o <= fault_d;
  end

  assert_rsvd_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == WK_CFG && wr_code_i > RC_STOP) |=> fault_o);

  assert_rsvd_kind_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == WK_RSVD) |=> fault_o);
endmodule

// File: rtl/ipf_range_slot.sv
module ipf_range_slot
  import ipf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_base_i,
  input  logic              we_limit_i,
  input  logic              we_cfg_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] ip_i,
  input  logic [ADDR_W-1:0] tgt_i,
  output logic              filt_en_o,
  output logic              filt_hit_o,
  output logic              stop_hit_o
);
  logic [ADDR_W-1:0] base_q, limit_q;
  logic [CFG_W-1:0]  cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      limit_q <= '0;
      cfg_q   <= RC_OFF;
    end else begin
      if (we_base_i)  base_q  <= wdata_i;
      if (we_limit_i) limit_q <= wdata_i;
      if (we_cfg_i)   cfg_q   <= wdata_i[CFG_W-1:0];
    end
  end

  // inverted span (base > limit) cannot satisfy both bounds
  logic ip_in, tgt_in;
  assign ip_in  = (ip_i  >= base_q) && (ip_i  <= limit_q);
  assign tgt_in = (tgt_i >= base_q) && (tgt_i <= limit_q);

  assign filt_en_o  = (cfg_q == RC_FILT);
  assign filt_hit_o = ip_in;
  assign stop_hit_o = (cfg_q == RC_STOP) && tgt_in;

  assert_cfg_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q <= RC_STOP);

  assert_inverted_no_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_q > limit_q) |-> !stop_hit_o);
endmodule

// File: rtl/ipf_merge.sv
module ipf_merge #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] filt_en_i,
  input  logic [N-1:0] filt_hit_i,
  input  logic [N-1:0] stop_hit_i,
  input  logic         branch_i,
  output logic         filter_en_o,
  output logic         trace_stop_o
);
  logic any_win, win_hit;
  assign any_win = |filt_en_i;
  assign win_hit = |(filt_en_i & filt_hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filter_en_o  <= 1'b1;
      trace_stop_o <= 1'b0;
    end else begin
      filter_en_o  <= any_win ? win_hit : 1'b1;
      trace_stop_o <= branch_i && (|stop_hit_i);
    end
  end

  assert_stop_on_branch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_stop_o |-> $past(branch_i));

  assert_unfiltered_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_win |=> filter_en_o);

  assert_window_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_hit |=> filter_en_o);
endmodule

// File: rtl/ipf_range_filter.sv
module ipf_range_filter
  import ipf_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned IMPL_RANGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] ip_i,
  input  logic              branch_i,
  input  logic [ADDR_W-1:0] branch_tgt_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic              filter_en_o,
  output logic              trace_stop_o,
  output logic              wr_fault_o
);
  logic [IMPL_RANGES-1:0] we_base, we_limit, we_cfg;
  logic [IMPL_RANGES-1:0] filt_en, filt_hit, stop_hit;

  ipf_wr_decode #(.IMPL_RANGES(IMPL_RANGES)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_kind_i  (wr_kind_i),
    .wr_sel_i   (wr_sel_i),
    .wr_code_i  (wr_data_i[CFG_W-1:0]),
    .we_base_o  (we_base),
    .we_limit_o (we_limit),
    .we_cfg_o   (we_cfg),
    .fault_o    (wr_fault_o)
  );

  for (genvar g = 0; g < IMPL_RANGES; g++) begin : g_slot
    ipf_range_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_base_i  (we_base[g]),
      .we_limit_i (we_limit[g]),
      .we_cfg_i   (we_cfg[g]),
      .wdata_i    (wr_data_i),
      .ip_i       (ip_i),
      .tgt_i      (branch_tgt_i),
      .filt_en_o  (filt_en[g]),
      .filt_hit_o (filt_hit[g]),
      .stop_hit_o (stop_hit[g])
    );
  end

  ipf_merge #(.N(IMPL_RANGES)) u_merge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .filt_en_i    (filt_en),
    .filt_hit_i   (filt_hit),
    .stop_hit_i   (stop_hit),
    .branch_i     (branch_i),
    .filter_en_o  (filter_en_o),
    .trace_stop_o (trace_stop_o)
  );

  assert_unimpl_cfg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_kind_i == WK_CFG && int'(wr_sel_i) >= int'(IMPL_RANGES)
     && wr_data_i[CFG_W-1:0] != RC_OFF) |=> wr_fault_o);

  assert_fault_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fault_o |-> $past(wr_en_i));
endmodule

// File: tb/ipf_range_filter_test.sv
`timescale 1ns/1ps
module ipf_range_filter_test;
  localparam int AW   = 6;
  localparam int IMPL = 3;
  localparam int SPAN = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] ip = '0, tgt = '0, wdata = '0;
  logic branch = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_kind = '0, wr_sel = '0;
  logic filt_o, stop_o, fault_o;

  int checks = 0, failures = 0;
  int m_base[4], m_lim[4], m_cfg[4];

  always #4 clk = ~clk;

  ipf_range_filter #(.ADDR_W(AW), .IMPL_RANGES(IMPL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ip_i(ip), .branch_i(branch),
    .branch_tgt_i(tgt), .wr_en_i(wr_en), .wr_kind_i(wr_kind),
    .wr_sel_i(wr_sel), .wr_data_i(wdata), .filter_en_o(filt_o),
    .trace_stop_o(stop_o), .wr_fault_o(fault_o)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic bit inr(int a, int b, int l);
    return a >= b && a <= l;
  endfunction

  function automatic bit exp_fault(int k, int s, int d);
    if (k == 3) return 1'b1;
    if (k == 2) begin
      if ((d & 15) > 2) return 1'b1;
      if (s >= IMPL && (d & 15) != 0) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic wr(string req, int k, int s, int d);
    bit f;
    f = exp_fault(k, s, d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'(k); wr_sel = 2'(s); wdata = AW'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk(req, "wr_fault_o", fault_o, f);
    if (!f && s < IMPL) begin
      if (k == 0) m_base[s] = d;
      else if (k == 1) m_lim[s] = d;
      else if (k == 2) m_cfg[s] = d & 15;
    end
  endtask

  task automatic drive(int a, bit br, int t);
    @(negedge clk);
    ip = AW'(a); branch = br; tgt = AW'(t);
    @(posedge clk); #1;
  endtask

  function automatic bit exp_filt(int a);
    bit any = 0, hit = 0;
    for (int i = 0; i < IMPL; i++)
      if (m_cfg[i] == 1) begin
        any = 1;
        if (inr(a, m_base[i], m_lim[i])) hit = 1;
      end
    return any ? hit : 1'b1;
  endfunction

  function automatic bit exp_stop(bit br, int t);
    bit hit = 0;
    for (int i = 0; i < IMPL; i++)
      if (m_cfg[i] == 2 && inr(t, m_base[i], m_lim[i])) hit = 1;
    return br && hit;
  endfunction

  task automatic sweep(string req);
    for (int a = 0; a < SPAN; a++) begin
      bit br;
      int t;
      br = (a % 3) != 0;
      t  = (a * 7 + 5) % SPAN;
      drive(a, br, t);
      chk(req, "filter_en_o", filt_o, exp_filt(a));
      chk(req, "trace_stop_o", stop_o, exp_stop(br, t));
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_lim[i] = 0; m_cfg[i] = 0; end
    #20;
    chk("R1", "filter_en_o in reset", filt_o, 1'b1);
    chk("R1", "trace_stop_o in reset", stop_o, 1'b0);
    chk("R1", "wr_fault_o in reset", fault_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    drive(7, 1'b1, 7);
    chk("R1", "filter_en_o after reset", filt_o, 1'b1);
    chk("R1", "trace_stop_o after reset", stop_o, 1'b0);
    sweep("R4 R1");

    // single window
    wr("R10", 0, 0, 10); wr("R10", 1, 0, 20); wr("R2", 2, 0, 1);
    sweep("R2");
    drive(10, 1'b0, 0); chk("R2", "low edge", filt_o, 1'b1);
    drive(20, 1'b0, 0); chk("R2", "high edge", filt_o, 1'b1);
    drive(21, 1'b0, 0); chk("R2", "above", filt_o, 1'b0);

    // second window ORed
    wr("R10", 0, 1, 30); wr("R10", 1, 1, 40); wr("R3", 2, 1, 1);
    sweep("R3");

    // stop region
    wr("R10", 0, 2, 50); wr("R10", 1, 2, 60); wr("R6", 2, 2, 2);
    sweep("R6 R3");
    drive(55, 1'b1, 55); chk("R6", "branch into stop", stop_o, 1'b1);
    drive(55, 1'b0, 55); chk("R6", "pulse ends", stop_o, 1'b0);
    drive(55, 1'b0, 60); chk("R7", "no branch in region", stop_o, 1'b0);
    drive(56, 1'b1, 49); chk("R6", "branch outside", stop_o, 1'b0);

    // inverted spans
    wr("R5", 0, 1, 45); wr("R5", 1, 1, 35);
    sweep("R5");
    drive(40, 1'b0, 0); chk("R5", "inverted window no match", filt_o, 1'b0);
    wr("R5", 0, 2, 61); wr("R5", 1, 2, 52);
    drive(55, 1'b1, 55); chk("R5", "inverted stop no match", stop_o, 1'b0);
    wr("R6", 0, 2, 50); wr("R6", 1, 2, 60);

    // rejected writes
    for (int c = 3; c < 16; c++) wr("R8", 2, 0, c);
    sweep("R8");
    wr("R10", 3, 0, 0);
    wr("R10", 3, 1, 2);
    sweep("R10");
    wr("R9", 2, 3, 1);
    wr("R9", 2, 3, 2);
    wr("R9", 2, 3, 0);
    wr("R8", 2, 0, 2);
    wr("R8", 2, 0, 0);

    // only stop ranges left: unfiltered
    wr("R4", 2, 1, 0);
    sweep("R4");
    wr("R4", 2, 2, 0);
    sweep("R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule